// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This block divides a dividend of twice the word width, given as a high word and a low word, by a single-word divisor. It returns a single-word quotient and a single-word remainder. It works in either unsigned or two's-complement signed mode, chosen per operation. A request is a one-cycle `start` pulse. The block raises `busy` while it works. When the result is on the outputs it pulses `done` for one cycle.

Internally the block converts signed operands to magnitudes and runs a restoring shift-and-subtract loop that retires one quotient bit per clock. It then restores the signs. Signed results truncate toward zero, so the remainder has the sign of the dividend. A zero divisor, or a quotient that cannot be represented in one word, raises `div_err` instead of producing a result. A zero divisor is detected at once, without running the loop.

Top module: `wide_divider`

## Requirements
- R1: The dividend is `{dvd_hi, dvd_lo}`. In unsigned mode (`sgn_mode`=0), when no error occurs, `quot` is the floor of dividend/divisor and `rem` is the dividend minus quot*divisor (for example 100/7 gives 14 r 2, and 1000000/7 gives 142857 r 1).
- R2: A zero divisor gives `done`=1 with `div_err`=1 in the cycle right after the accepting edge, and `busy` is never raised for it.
- R3: In unsigned mode, a quotient of 2^W or more raises `div_err`.
- R4: In signed mode (`sgn_mode`=1), the quotient truncates toward zero and a nonzero remainder carries the sign of the dividend (-100/7 gives -14 r -2, 100/-7 gives -14 r 2, and -100/-7 gives 14 r -2).
- R5: In signed mode, `div_err` is raised when the true quotient lies outside -2^(W-1) .. 2^(W-1)-1. A quotient of exactly -2^(W-1) is valid.
- R6: Whenever `div_err` is reported, `quot` and `rem` are both zero.
- R7: For a nonzero divisor, `busy` goes high after the accepting edge and stays high for exactly 2W cycles. `done` rises in the same cycle that `busy` falls, and `busy` and `done` are never high together.
- R8: A `start` seen while `busy` is high is ignored, and the running operation completes with its original operands and timing.
- R9: `done` lasts one cycle. `quot`, `rem` and `div_err` keep their value from one completion to the next.
- R10: After reset, `busy`, `done`, `div_err`, `quot` and `rem` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (sampled only when idle) |
| sgn_mode | input | 1 | 1 = signed, 0 = unsigned |
| dvd_hi | input | W | Upper word of dividend |
| dvd_lo | input | W | Lower word of dividend |
| dvsr | input | W | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | W | Quotient |
| rem | output | W | Remainder |
| div_err | output | 1 | Zero divisor or quotient overflow |

## Verification
The bench targets the overflow boundaries at both edges of each range:
- Unsigned: a high word one below the divisor, which fits, against a division by one, which does not.
- Signed: a quotient of exactly -2^(W-1), which fits, against +2^(W-1), which does not.

An off-by-one in the limit check would flag the legal case or pass the illegal one. Sign mixes of dividend and divisor expose a fixup that floors instead of truncating, or that gives the remainder the divisor's sign. A start pulse injected mid-operation would restart or corrupt a design that samples it while busy. The zero-divisor case shows whether the design runs the full loop when it should finish at once.

// File: rtl/wide_div_pkg.sv
package wide_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/wide_div_mag.sv
// Two's-complement magnitude of a value when signed handling is enabled.
module wide_div_mag #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             sgn_i,
  output logic             neg_o,
  output logic [WIDTH-1:0] mag_o
);
  always_comb begin
    neg_o = sgn_i & val_i[WIDTH-1];
    mag_o = neg_o ? (~val_i + WIDTH'(1)) : val_i;
  end
endmodule

// File: rtl/wide_div_step.sv
// One restoring iteration: shift in the next dividend bit, trial-subtract.
module wide_div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0]   prem_i,
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   dvsr_i,
  output logic [W-1:0]   prem_o,
  output logic [2*W-1:0] acc_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {prem_i, acc_i[2*W-1]};
    diff    = shifted - {1'b0, dvsr_i};
    fits    = ~diff[W];
    prem_o  = fits ? diff[W-1:0] : shifted[W-1:0];
    acc_o   = {acc_i[2*W-2:0], fits};
  end
endmodule

// File: rtl/wide_div_fix.sv
// Range check on the magnitude quotient and sign restoration.
module wide_div_fix #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] qmag_i,
  input  logic [W-1:0]   rmag_i,
  input  logic           sgn_i,
  input  logic           qneg_i,
  input  logic           rneg_i,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o,
  output logic           err_o
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic       hi_nz;
  logic [W-1:0] lim;

  always_comb begin
    hi_nz = |qmag_i[2*W-1:W];
    lim   = qneg_i ? NEG_LIM : POS_LIM;
    if (sgn_i) err_o = hi_nz | (qmag_i[W-1:0] > lim);
    else       err_o = hi_nz;
    if (err_o) begin
      quot_o = '0;
      rem_o  = '0;
    end else begin
      quot_o = qneg_i ? (~qmag_i[W-1:0] + W'(1)) : qmag_i[W-1:0];
      rem_o  = rneg_i ? (~rmag_i + W'(1)) : rmag_i;
    end
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wide_div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn_mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvsr,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         div_err
);
  localparam int           ITER = 2 * W;
  localparam int           CW   = $clog2(ITER);
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  div_state_e        state_q, state_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [2*W-1:0]    acc_q, acc_n;
  logic [W-1:0]      prem_q, prem_n;
  logic [W-1:0]      dvsr_q, dvsr_n;
  logic              sgn_q, sgn_n, qneg_q, qneg_n, rneg_q, rneg_n;
  logic [W-1:0]      quot_q, quot_n, rem_q, rem_n;
  logic              err_q, err_n, done_q, done_n;
  logic              dp_en, out_en;

  // operand conditioning
  logic              dvd_neg, dvs_neg;
  logic [2*W-1:0]    dvd_mag;
  logic [W-1:0]      dvs_mag;

  wide_div_mag #(.WIDTH(2*W)) u_mag_dvd (
    .val_i(({dvd_hi, dvd_lo})), .sgn_i(sgn_mode), .neg_o(dvd_neg), .mag_o(dvd_mag));
  wide_div_mag #(.WIDTH(W)) u_mag_dvs (
    .val_i(dvsr), .sgn_i(sgn_mode), .neg_o(dvs_neg), .mag_o(dvs_mag));

  // iteration datapath
  logic [W-1:0]   step_prem;
  logic [2*W-1:0] step_acc;
  wide_div_step #(.W(W)) u_step (
    .prem_i(prem_q), .acc_i(acc_q), .dvsr_i(dvsr_q),
    .prem_o(step_prem), .acc_o(step_acc));

  // final fixup on the last step's output
  logic [W-1:0] fix_quot, fix_rem;
  logic         fix_err;
  wide_div_fix #(.W(W)) u_fix (
    .qmag_i(step_acc), .rmag_i(step_prem), .sgn_i(sgn_q),
    .qneg_i(qneg_q), .rneg_i(rneg_q),
    .quot_o(fix_quot), .rem_o(fix_rem), .err_o(fix_err));

  // next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    prem_n  = prem_q;
    dvsr_n  = dvsr_q;
    sgn_n   = sgn_q;
    qneg_n  = qneg_q;
    rneg_n  = rneg_q;
    quot_n  = quot_q;
    rem_n   = rem_q;
    err_n   = err_q;
    done_n  = 1'b0;
    dp_en   = 1'b0;
    out_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (dvsr == '0) begin
            out_en = 1'b1;
            done_n = 1'b1;
            err_n  = 1'b1;
            quot_n = '0;
            rem_n  = '0;
          end else begin
            dp_en   = 1'b1;
            state_n = ST_RUN;
            cnt_n   = '0;
            acc_n   = dvd_mag;
            prem_n  = '0;
            dvsr_n  = dvs_mag;
            sgn_n   = sgn_mode;
            qneg_n  = dvd_neg ^ dvs_neg;
            rneg_n  = dvd_neg;
          end
        end
      end
      ST_RUN: begin
        dp_en  = 1'b1;
        acc_n  = step_acc;
        prem_n = step_prem;
        cnt_n  = cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          state_n = ST_IDLE;
          out_en  = 1'b1;
          done_n  = 1'b1;
          quot_n  = fix_quot;
          rem_n   = fix_rem;
          err_n   = fix_err;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      prem_q <= '0;
      dvsr_q <= '0;
      sgn_q  <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
    end else if (dp_en) begin
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      prem_q <= prem_n;
      dvsr_q <= dvsr_n;
      sgn_q  <= sgn_n;
      qneg_q <= qneg_n;
      rneg_q <= rneg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      quot_q <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
    end else if (out_en) begin
      quot_q <= quot_n;
      rem_q  <= rem_n;
      err_q  <= err_n;
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign done    = done_q;
  assign quot    = quot_q;
  assign rem     = rem_q;
  assign div_err = err_q;

  // assertions
  p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && start && dvsr == '0) |=> (done && div_err && !busy));

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(busy && done));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !start) |=> ($stable(quot) && $stable(rem) && $stable(div_err)));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start) |=> ($stable(dvsr_q) && $stable(sgn_q) && $stable(qneg_q)));

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && div_err) |-> (quot == '0 && rem == '0));

  p_rem_sign_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !div_err && sgn_q && rem != '0) |-> (rem[W-1] == rneg_q));

  p_prem_bound_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> (prem_q < dvsr_q));
endmodule

// File: tb/wide_divider_tb_top.sv
`timescale 1ns/1ps
module wide_divider_tb_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         sgn_mode;
  logic [W-1:0] dvd_hi, dvd_lo, dvsr;
  logic         busy, done, div_err;
  logic [W-1:0] quot, rem;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "R10";
  logic cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  wide_divider #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
    .busy(busy), .done(done), .quot(quot), .rem(rem), .div_err(div_err));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference
  function automatic void ref_div(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                  input logic [W-1:0] d, input logic s,
                                  output logic [W-1:0] q, output logic [W-1:0] r,
                                  output logic e);
    logic [2*W-1:0] n, uq, ur;
    logic signed [2*W-1:0] sn, sd, sq, sr;
    n = {hi, lo};
    if (d == '0) begin
      q = '0; r = '0; e = 1'b1;
      return;
    end
    if (!s) begin
      uq = n / {{W{1'b0}}, d};
      ur = n % {{W{1'b0}}, d};
      e  = (uq[2*W-1:W] != '0);
      q  = uq[W-1:0];
      r  = ur[W-1:0];
    end else begin
      sn = $signed(n);
      sd = $signed({{W{d[W-1]}}, d});
      sq = sn / sd;
      sr = sn % sd;
      e  = (sq != {{W{sq[W-1]}}, sq[W-1:0]}) || (n == {1'b1, {(2*W-1){1'b0}}} && d == '1);
      q  = sq[W-1:0];
      r  = sr[W-1:0];
    end
    if (e) begin q = '0; r = '0; end
  endfunction

  // cycle model
  logic         m_busy, m_done, m_e, p_e;
  logic [W-1:0] m_q, m_r, p_q, p_r;
  int           m_left;
  logic [W-1:0] t_q, t_r;
  logic         t_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_e <= 1'b0;
      m_q <= '0; m_r <= '0; m_left <= 0;
      p_q <= '0; p_r <= '0; p_e <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        ref_div(dvd_hi, dvd_lo, dvsr, sgn_mode, t_q, t_r, t_e);
        if (dvsr == '0) begin
          m_done <= 1'b1; m_e <= 1'b1; m_q <= '0; m_r <= '0;
        end else begin
          m_busy <= 1'b1; m_left <= 2*W;
          p_q <= t_q; p_r <= t_r; p_e <= t_e;
        end
      end else if (m_busy) begin
        m_left <= m_left - 1;
        if (m_left == 1) begin
          m_busy <= 1'b0; m_done <= 1'b1;
          m_q <= p_q; m_r <= p_r; m_e <= p_e;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy == m_busy, "R7", "busy", W'(busy), W'(m_busy));
      chk(done == m_done, "R9", "done", W'(done), W'(m_done));
      chk(quot == m_q, cur_tag, "quot", quot, m_q);
      chk(rem == m_r, cur_tag, "rem", rem, m_r);
      chk(div_err == m_e, cur_tag, "div_err", W'(div_err), W'(m_e));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic run_op(input logic [W-1:0] hi, input logic [W-1:0] lo,
                        input logic [W-1:0] d, input logic s, input string tag);
    @(negedge clk);
    cur_tag = tag;
    dvd_hi = hi; dvd_lo = lo; dvsr = d; sgn_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dvd_hi = ~hi; dvd_lo = ~lo; dvsr = ~d; sgn_mode = ~s;
    repeat (2*W + 4) @(negedge clk);
  endtask

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  initial begin
    rst_n = 1'b0; start = 1'b0; sgn_mode = 1'b0;
    dvd_hi = '0; dvd_lo = '0; dvsr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done", W'({busy, done}), '0);
    chk(quot == '0 && rem == '0 && div_err == 1'b0, "R10", "quot/rem/err",
        quot | rem | W'(div_err), '0);
    cmp_en = 1'b1;

    // R1: unsigned results
    run_op('0, W'(100), W'(7), 1'b0, "R1");
    run_op('0, W'(1000000), W'(7), 1'b0, "R1");
    run_op(W'(3), 64'h0123_4567_89AB_CDEF, 64'hF000_0000_0000_0001, 1'b0, "R1");
    // R3: unsigned fit boundary, then overflow
    run_op(W'(6), ONES, W'(7), 1'b0, "R3");
    run_op(W'(5), '0, W'(1), 1'b0, "R3");
    run_op(W'(7), '0, W'(7), 1'b0, "R3");
    // R2 / R6: zero divisor
    run_op(W'(9), W'(9), '0, 1'b0, "R2");
    run_op(ONES, ONES, '0, 1'b1, "R6");
    // R4: signed truncation and remainder sign
    run_op(ONES, -W'(100), W'(7), 1'b1, "R4");
    run_op('0, W'(100), -W'(7), 1'b1, "R4");
    run_op(ONES, -W'(100), -W'(7), 1'b1, "R4");
    run_op(ONES, -W'(7), W'(2), 1'b1, "R4");
    // R5: signed range edges
    run_op(ONES, MINW, W'(1), 1'b1, "R5");
    run_op('0, MINW, W'(1), 1'b1, "R5");
    run_op(ONES, MINW, ONES, 1'b1, "R5");
    run_op('0, MINW - W'(1), W'(1), 1'b1, "R5");
    run_op(MINW, '0, ONES, 1'b1, "R5");

    // R8: start while busy is ignored
    @(negedge clk);
    cur_tag = "R8";
    dvd_hi = '0; dvd_lo = W'(1000); dvsr = W'(9); sgn_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dvd_hi = '0; dvd_lo = W'(50); dvsr = '0; start = 1'b1;
    @(negedge clk);
    dvsr = W'(3); sgn_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2*W) @(negedge clk);
    chk(quot == W'(111) && rem == W'(1), "R8", "quot after ignored start",
        quot, W'(111));

    // R9: outputs hold while idle
    cur_tag = "R9";
    repeat (10) @(negedge clk);
    chk(quot == W'(111) && !done, "R9", "held quot", quot, W'(111));

    cmp_en = 1'b0;
    finish_run();
  end
endmodule